// File: doc/BRIEF.md
# CPU Processing State Controller

This block keeps track of the processing state of a small CPU core. A core is always in exactly one of five visible states: reset, exception handling, program execution, power-down, or bus-released. The controller moves between these states in response to the reset pin, the NMI pin, interrupt and DMA address-error requests, a decoded SLEEP instruction strobe and an external bus request. From the current state it drives the clock enables for the CPU, the peripherals and the oscillator. It also drives the bus grant.

Each path into exception handling produces a one-cycle start strobe for the exception sequencer, together with a cause code. The sequencer answers with a vector-done pulse, which returns the core to program execution. The level of the NMI pin while reset is held decides whether the reset was a power-on reset or a manual reset.

A SLEEP strobe leads to one of two power-down modes, selected by a standby-select bit. In the light mode only the CPU stops. In the deep mode the CPU, the peripherals and the oscillator all stop, and leaving it requires a timed oscillator settle window.

Top module: `cpu_pstate_ctrl`

## Requirements
- R1: While `rst_pin_n` is low, the controller is in the reset state at once (asynchronously), from any state. In that state `state_oh` is 5'b00001, `cpu_clk_en` is 0, `periph_clk_en` is 1, `osc_en` is 1 and `bus_grant` is 0. The `state_oh` bits are: bit0 reset, bit1 exception handling, bit2 program execution, bit3 power-down, bit4 bus-released.
- R2: `rst_poweron` takes the level of `nmi_pin` sampled while reset is held (1 means power-on reset, 0 means manual reset). It keeps that value until the next reset.
- R3: On the first rising clock edge after reset is released, the state becomes exception handling (bit1) with `exc_start`=1 and `exc_cause`=0. A `vec_done` pulse in exception handling moves the state to program execution (bit2) on the next edge.
- R4: `exc_start` is high for exactly one cycle, on each entry to exception handling. `exc_cause` carries 0 for reset, 1 for an interrupt (`irq_req` or a rising edge on `nmi_pin`) and 2 for `dma_addr_err`. During program execution an interrupt or a DMA address error starts exception handling on the next edge.
- R5: A `sleep_strobe` with `standby_sel`=0 during program execution enters power-down (bit3) in light mode: `cpu_clk_en`=0, `periph_clk_en`=1, `osc_en`=1.
- R6: Light power-down is left only through exception handling. `dma_addr_err` gives cause 2; `irq_req` or a rising edge on `nmi_pin` gives cause 1.
- R7: A `sleep_strobe` with `standby_sel`=1 and `dma_master_en`=0 enters power-down in deep mode. In deep mode `cpu_clk_en`, `periph_clk_en` and `osc_en` are all 0.
- R8: A `sleep_strobe` with `standby_sel`=1 while `dma_master_en`=1 is ignored. The state stays in program execution and `standby_err` is 1 for exactly the cycle after the strobe.
- R9: In deep mode, `irq_req` and `dma_addr_err` have no effect. Only a rising edge on `nmi_pin`, or reset, leaves it.
- R10: After the waking NMI edge, `osc_en` is 1 from the next edge onward. The state stays power-down with `cpu_clk_en`=`periph_clk_en`=0 for `SETTLE_CYCLES` cycles (default 16). Then exception handling starts with cause 1.
- R11: `bus_req` during program execution moves the state to bus-released (bit4) with `bus_grant`=1 on the next edge. When the request drops, the next edge returns to program execution with `bus_grant`=0.
- R12: When several requests arrive together in program execution, the priority is: DMA address error first, then interrupt, then bus request, then SLEEP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_pin_n | input | 1 | Reset pin, active low, asynchronous entry |
| nmi_pin | input | 1 | NMI pin level; sets the reset type and wakes the core on a rising edge |
| irq_req | input | 1 | Ordinary interrupt request |
| dma_addr_err | input | 1 | DMA address-error flag |
| sleep_strobe | input | 1 | One-cycle decoded SLEEP instruction |
| standby_sel | input | 1 | Power-down mode select: 0 light, 1 deep |
| dma_master_en | input | 1 | DMA controller master enable |
| bus_req | input | 1 | External bus request |
| vec_done | input | 1 | Exception sequencer finished its vector fetch |
| state_oh | output | 5 | One-hot visible processing state |
| rst_poweron | output | 1 | 1 after a power-on reset, 0 after a manual reset |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| bus_grant | output | 1 | Bus granted to the external requester |
| exc_start | output | 1 | One-cycle exception start strobe |
| exc_cause | output | 2 | Cause code sent with `exc_start` |
| standby_err | output | 1 | Pulse when a deep power-down is refused |

## Verification
Each request sampled at a rising edge shows up in `state_oh` and the enables one edge later. `exc_start`, `exc_cause` and `standby_err` are registered in that same edge, so they are valid for exactly that following cycle. Reset is the exception: it acts at once, without waiting for an edge.

The deep-mode wake takes `SETTLE_CYCLES` edges in the settle window plus one further edge into exception handling. The bench therefore counts sixteen power-down cycles after the wake edge before it expects the strobe.

Inputs are driven on the falling edge and results are read on the next falling edge. Each read lands exactly one rising edge after its stimulus.

// File: rtl/pstate_pkg.sv
package pstate_pkg;

  typedef enum logic [2:0] {
    ST_RESET  = 3'd0,
    ST_EXCP   = 3'd1,
    ST_EXEC   = 3'd2,
    ST_SLEEP  = 3'd3,
    ST_STBY   = 3'd4,
    ST_SETTLE = 3'd5,
    ST_BUSREL = 3'd6
  } pstate_e;

  localparam int VIS_W      = 5;
  localparam int VIS_RESET  = 0;
  localparam int VIS_EXCP   = 1;
  localparam int VIS_EXEC   = 2;
  localparam int VIS_PDOWN  = 3;
  localparam int VIS_BUSREL = 4;

  typedef logic [1:0] cause_t;
  localparam cause_t CAUSE_RESET  = 2'd0;
  localparam cause_t CAUSE_IRQ    = 2'd1;
  localparam cause_t CAUSE_DMAERR = 2'd2;

  typedef struct packed {
    logic cpu;
    logic periph;
    logic osc;
    logic grant;
  } enables_t;

  function automatic logic f_is_pdown(input pstate_e s);
    return (s == ST_SLEEP) || (s == ST_STBY) || (s == ST_SETTLE);
  endfunction

  function automatic logic [VIS_W-1:0] f_visible(input pstate_e s);
    logic [VIS_W-1:0] v;
    v = '0;
    case (s)
      ST_RESET:  v[VIS_RESET]  = 1'b1;
      ST_EXCP:   v[VIS_EXCP]   = 1'b1;
      ST_EXEC:   v[VIS_EXEC]   = 1'b1;
      ST_BUSREL: v[VIS_BUSREL] = 1'b1;
      default:   v[VIS_PDOWN]  = 1'b1;
    endcase
    return v;
  endfunction

  function automatic enables_t f_enables(input pstate_e s);
    enables_t e;
    case (s)
      ST_RESET:  e = '{cpu: 1'b0, periph: 1'b1, osc: 1'b1, grant: 1'b0};
      ST_EXCP:   e = '{cpu: 1'b1, periph: 1'b1, osc: 1'b1, grant: 1'b0};
      ST_EXEC:   e = '{cpu: 1'b1, periph: 1'b1, osc: 1'b1, grant: 1'b0};
      ST_SLEEP:  e = '{cpu: 1'b0, periph: 1'b1, osc: 1'b1, grant: 1'b0};
      ST_SETTLE: e = '{cpu: 1'b0, periph: 1'b0, osc: 1'b1, grant: 1'b0};
      ST_BUSREL: e = '{cpu: 1'b0, periph: 1'b1, osc: 1'b1, grant: 1'b1};
      default:   e = '{cpu: 1'b0, periph: 1'b0, osc: 1'b0, grant: 1'b0};
    endcase
    return e;
  endfunction

  // Cause for a wake or exception request: DMA error outranks interrupts.
  function automatic cause_t f_req_cause(input logic dma_err);
    return dma_err ? CAUSE_DMAERR : CAUSE_IRQ;
  endfunction

endpackage

// File: rtl/pstate_rst_capture.sv
module pstate_rst_capture (
  input  logic clk,
  input  logic rst_pin_n,
  input  logic nmi_pin,
  output logic rst_poweron,
  output logic nmi_rise
);

  logic nmi_q;

  // While reset is held the NMI level is sampled each edge; the last
  // sample before release decides the reset type.
  always_ff @(posedge clk or negedge rst_pin_n) begin
    if (!rst_pin_n) begin
      rst_poweron <= nmi_pin;
      nmi_q       <= nmi_pin;
    end else begin
      nmi_q       <= nmi_pin;
    end
  end

  assign nmi_rise = nmi_pin & ~nmi_q;

  AST_TYPE_HELD: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $stable(rst_poweron) || $rose(rst_pin_n)) else $error("reset type changed"); // R2

endmodule

// File: rtl/pstate_settle.sv
module pstate_settle #(
  parameter int SETTLE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic done
);

  localparam int CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= LOAD_VAL;
    else if (run && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = run && (cnt == '0);

  AST_SETTLE_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !done) else $error("settle finished at once"); // R10

endmodule

// File: rtl/pstate_fsm.sv
module pstate_fsm
  import pstate_pkg::*;
(
  input  logic    clk,
  input  logic    rst_pin_n,
  input  logic    nmi_rise,
  input  logic    irq_req,
  input  logic    dma_addr_err,
  input  logic    sleep_strobe,
  input  logic    standby_sel,
  input  logic    dma_master_en,
  input  logic    bus_req,
  input  logic    vec_done,
  input  logic    settle_done,
  output pstate_e state,
  output logic    settle_load,
  output logic    exc_start,
  output cause_t  exc_cause,
  output logic    standby_err
);

  pstate_e nxt;
  logic    go_exc;
  cause_t  cause_nxt;
  logic    refuse;
  logic    int_req;

  assign int_req = irq_req | nmi_rise;

  always_comb begin
    nxt         = state;
    go_exc      = 1'b0;
    cause_nxt   = CAUSE_RESET;
    refuse      = 1'b0;
    settle_load = 1'b0;
    case (state)
      ST_RESET: begin
        nxt    = ST_EXCP;
        go_exc = 1'b1;
      end
      ST_EXCP: begin
        if (vec_done) nxt = ST_EXEC;
      end
      ST_EXEC: begin
        if (dma_addr_err || int_req) begin
          nxt       = ST_EXCP;
          go_exc    = 1'b1;
          cause_nxt = f_req_cause(dma_addr_err);
        end else if (bus_req) begin
          nxt = ST_BUSREL;
        end else if (sleep_strobe) begin
          if (!standby_sel)        nxt = ST_SLEEP;
          else if (!dma_master_en) nxt = ST_STBY;
          else                     refuse = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (dma_addr_err || int_req) begin
          nxt       = ST_EXCP;
          go_exc    = 1'b1;
          cause_nxt = f_req_cause(dma_addr_err);
        end
      end
      ST_STBY: begin
        if (nmi_rise) begin
          nxt         = ST_SETTLE;
          settle_load = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (settle_done) begin
          nxt       = ST_EXCP;
          go_exc    = 1'b1;
          cause_nxt = CAUSE_IRQ;
        end
      end
      ST_BUSREL: begin
        if (!bus_req) nxt = ST_EXEC;
      end
      default: nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_pin_n) begin
    if (!rst_pin_n) begin
      state       <= ST_RESET;
      exc_start   <= 1'b0;
      exc_cause   <= CAUSE_RESET;
      standby_err <= 1'b0;
    end else begin
      state       <= nxt;
      exc_start   <= go_exc;
      standby_err <= refuse;
      if (go_exc) exc_cause <= cause_nxt;
    end
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_pin_n)
    exc_start |=> !exc_start) else $error("start strobe too long"); // R4
  AST_START_IN_EXCP: assert property (@(posedge clk) disable iff (!rst_pin_n)
    exc_start |-> state == ST_EXCP) else $error("strobe outside exception"); // R3
  AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (!rst_pin_n)
    exc_start |-> exc_cause != 2'd3) else $error("illegal cause"); // R4
  AST_REFUSE_STAYS: assert property (@(posedge clk) disable iff (!rst_pin_n)
    standby_err |-> state == ST_EXEC) else $error("refused standby left exec"); // R8
  AST_STBY_DEAF: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (state == ST_STBY) && !nmi_rise |=> state == ST_STBY) else $error("standby woke"); // R9
  AST_WAKE_VIA_EXCP: assert property (@(posedge clk) disable iff (!rst_pin_n)
    f_is_pdown(state) |=> f_is_pdown(state) || state == ST_EXCP) else $error("bad wake"); // R6

endmodule

// File: rtl/pstate_outdec.sv
module pstate_outdec
  import pstate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_pin_n,
  input  pstate_e          state,
  output logic [VIS_W-1:0] state_oh,
  output logic             cpu_clk_en,
  output logic             periph_clk_en,
  output logic             osc_en,
  output logic             bus_grant
);

  enables_t en;

  assign en            = f_enables(state);
  assign state_oh      = f_visible(state);
  assign cpu_clk_en    = en.cpu;
  assign periph_clk_en = en.periph;
  assign osc_en        = en.osc;
  assign bus_grant     = en.grant;

  AST_ONE_STATE: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $countones(state_oh) == 1) else $error("state not one-hot"); // R1
  AST_OSC_OFF_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_pin_n)
    !osc_en |-> !cpu_clk_en && !periph_clk_en && state_oh[VIS_PDOWN]) else $error("osc off"); // R7

endmodule

// File: rtl/cpu_pstate_ctrl.sv
module cpu_pstate_ctrl
  import pstate_pkg::*;
#(
  parameter int SETTLE_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_pin_n,
  input  logic       nmi_pin,
  input  logic       irq_req,
  input  logic       dma_addr_err,
  input  logic       sleep_strobe,
  input  logic       standby_sel,
  input  logic       dma_master_en,
  input  logic       bus_req,
  input  logic       vec_done,
  output logic [4:0] state_oh,
  output logic       rst_poweron,
  output logic       cpu_clk_en,
  output logic       periph_clk_en,
  output logic       osc_en,
  output logic       bus_grant,
  output logic       exc_start,
  output logic [1:0] exc_cause,
  output logic       standby_err
);

  pstate_e state;
  logic    nmi_rise;
  logic    settle_load;
  logic    settle_done;
  logic    settle_run;

  assign settle_run = (state == ST_SETTLE);

  pstate_rst_capture u_rst (
    .clk         (clk),
    .rst_pin_n   (rst_pin_n),
    .nmi_pin     (nmi_pin),
    .rst_poweron (rst_poweron),
    .nmi_rise    (nmi_rise)
  );

  pstate_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk   (clk),
    .rst_n (rst_pin_n),
    .load  (settle_load),
    .run   (settle_run),
    .done  (settle_done)
  );

  pstate_fsm u_fsm (
    .clk           (clk),
    .rst_pin_n     (rst_pin_n),
    .nmi_rise      (nmi_rise),
    .irq_req       (irq_req),
    .dma_addr_err  (dma_addr_err),
    .sleep_strobe  (sleep_strobe),
    .standby_sel   (standby_sel),
    .dma_master_en (dma_master_en),
    .bus_req       (bus_req),
    .vec_done      (vec_done),
    .settle_done   (settle_done),
    .state         (state),
    .settle_load   (settle_load),
    .exc_start     (exc_start),
    .exc_cause     (exc_cause),
    .standby_err   (standby_err)
  );

  pstate_outdec u_out (
    .clk           (clk),
    .rst_pin_n     (rst_pin_n),
    .state         (state),
    .state_oh      (state_oh),
    .cpu_clk_en    (cpu_clk_en),
    .periph_clk_en (periph_clk_en),
    .osc_en        (osc_en),
    .bus_grant     (bus_grant)
  );

  AST_GRANT_DROP: assert property (@(posedge clk) disable iff (!rst_pin_n)
    bus_grant && !bus_req |=> !bus_grant) else $error("grant held"); // R11
  AST_SETTLE_OSC: assert property (@(posedge clk) disable iff (!rst_pin_n)
    settle_run |=> osc_en) else $error("osc dropped in settle"); // R10

endmodule

// File: tb/sim_cpu_pstate_ctrl.sv
`timescale 1ns/100ps
module sim_cpu_pstate_ctrl;

  localparam int SETTLE = 16;

  logic clk = 1'b0;
  logic rst_pin_n = 1'b0, nmi_pin = 1'b0, irq_req = 1'b0, dma_addr_err = 1'b0;
  logic sleep_strobe = 1'b0, standby_sel = 1'b0, dma_master_en = 1'b0;
  logic bus_req = 1'b0, vec_done = 1'b0;
  logic [4:0] state_oh;
  logic rst_poweron, cpu_clk_en, periph_clk_en, osc_en, bus_grant;
  logic exc_start, standby_err;
  logic [1:0] exc_cause;

  int n_tests = 0;
  int n_fail  = 0;
  bit ended   = 1'b0;

  localparam logic [4:0] V_RST = 5'b00001, V_EXC = 5'b00010, V_EXE = 5'b00100,
                         V_PD  = 5'b01000, V_BUS = 5'b10000;

  always #2.5 clk = ~clk;

  cpu_pstate_ctrl #(.SETTLE_CYCLES(SETTLE)) u0 (
    .clk(clk), .rst_pin_n(rst_pin_n), .nmi_pin(nmi_pin), .irq_req(irq_req),
    .dma_addr_err(dma_addr_err), .sleep_strobe(sleep_strobe),
    .standby_sel(standby_sel), .dma_master_en(dma_master_en),
    .bus_req(bus_req), .vec_done(vec_done), .state_oh(state_oh),
    .rst_poweron(rst_poweron), .cpu_clk_en(cpu_clk_en),
    .periph_clk_en(periph_clk_en), .osc_en(osc_en), .bus_grant(bus_grant),
    .exc_start(exc_start), .exc_cause(exc_cause), .standby_err(standby_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Enables packed as {cpu, periph, osc, grant}
  function automatic logic [3:0] ens();
    return {cpu_clk_en, periph_clk_en, osc_en, bus_grant};
  endfunction

  task automatic finish_vector();
    vec_done = 1'b1; tick(); vec_done = 1'b0;
    chk("R3 back to execution", state_oh, V_EXE);
    chk("R4 strobe one cycle", exc_start, 1'b0);
  endtask

  task automatic t_reset(input logic lvl);
    tick();
    nmi_pin = lvl; rst_pin_n = 1'b0;
    #1;
    chk("R1 async reset state", state_oh, V_RST);
    chk("R1 reset enables", ens(), 4'b0110);
    tick(); tick();
    rst_pin_n = 1'b1;
    tick();
    chk("R3 exception after release", state_oh, V_EXC);
    chk("R3 start strobe", exc_start, 1'b1);
    chk("R3 reset cause", exc_cause, 2'd0);
    chk("R2 reset type", rst_poweron, lvl);
    nmi_pin = 1'b0;
    finish_vector();
  endtask

  task automatic t_exec_exceptions();
    irq_req = 1'b1; dma_addr_err = 1'b1; bus_req = 1'b1; sleep_strobe = 1'b1;
    tick();
    irq_req = 1'b0; dma_addr_err = 1'b0; bus_req = 1'b0; sleep_strobe = 1'b0;
    chk("R12 dma error wins", state_oh, V_EXC);
    chk("R4 dma cause", exc_cause, 2'd2);
    chk("R4 strobe", exc_start, 1'b1);
    finish_vector();
    irq_req = 1'b1; bus_req = 1'b1;
    tick();
    irq_req = 1'b0; bus_req = 1'b0;
    chk("R12 interrupt over bus", state_oh, V_EXC);
    chk("R4 interrupt cause", exc_cause, 2'd1);
    finish_vector();
    bus_req = 1'b1; sleep_strobe = 1'b1;
    tick();
    sleep_strobe = 1'b0; bus_req = 1'b0;
    chk("R12 bus over sleep", state_oh, V_BUS);
    tick();
    chk("R12 back from bus", state_oh, V_EXE);
  endtask

  task automatic t_bus();
    bus_req = 1'b1;
    tick();
    chk("R11 bus released", state_oh, V_BUS);
    chk("R11 grant", bus_grant, 1'b1);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R11 grant held", bus_grant, 1'b1);
    end
    bus_req = 1'b0;
    tick();
    chk("R11 grant withdrawn", bus_grant, 1'b0);
    chk("R11 back to execution", state_oh, V_EXE);
  endtask

  // kind: 0 irq, 1 dma error, 2 nmi edge
  task automatic t_sleep(input int kind);
    standby_sel = 1'b0; sleep_strobe = 1'b1;
    tick();
    sleep_strobe = 1'b0;
    chk("R5 light power-down", state_oh, V_PD);
    chk("R5 light enables", ens(), 4'b0110);
    tick(); tick();
    chk("R5 still asleep", state_oh, V_PD);
    if (kind == 0) irq_req = 1'b1;
    else if (kind == 1) dma_addr_err = 1'b1;
    else nmi_pin = 1'b1;
    tick();
    irq_req = 1'b0; dma_addr_err = 1'b0; nmi_pin = 1'b0;
    chk("R6 wake through exception", state_oh, V_EXC);
    chk("R6 wake strobe", exc_start, 1'b1);
    chk("R6 wake cause", exc_cause, (kind == 1) ? 2'd2 : 2'd1);
    finish_vector();
  endtask

  task automatic t_refuse();
    standby_sel = 1'b1; dma_master_en = 1'b1; sleep_strobe = 1'b1;
    tick();
    sleep_strobe = 1'b0;
    chk("R8 stays in execution", state_oh, V_EXE);
    chk("R8 error pulse", standby_err, 1'b1);
    chk("R8 enables kept", ens(), 4'b1110);
    tick();
    chk("R8 error one cycle", standby_err, 1'b0);
    dma_master_en = 1'b0;
  endtask

  task automatic t_standby();
    standby_sel = 1'b1; dma_master_en = 1'b0; sleep_strobe = 1'b1;
    tick();
    sleep_strobe = 1'b0;
    chk("R7 deep power-down", state_oh, V_PD);
    chk("R7 all enables off", ens(), 4'b0000);
    irq_req = 1'b1; dma_addr_err = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R9 ignores irq and dma", {state_oh, osc_en, exc_start}, {V_PD, 2'b00});
    end
    irq_req = 1'b0; dma_addr_err = 1'b0;
    nmi_pin = 1'b1;
    tick();
    chk("R10 osc back on", ens(), 4'b0010);
    chk("R10 still power-down", state_oh, V_PD);
    for (int i = 1; i < SETTLE; i++) begin
      tick();
      chk("R10 settling", {state_oh, cpu_clk_en, periph_clk_en, exc_start}, {V_PD, 3'b000});
    end
    tick();
    chk("R10 exception after settle", state_oh, V_EXC);
    chk("R10 strobe", exc_start, 1'b1);
    chk("R10 cause", exc_cause, 2'd1);
    nmi_pin = 1'b0;
    finish_vector();
    standby_sel = 1'b0;
  endtask

  task automatic t_reset_from_standby();
    standby_sel = 1'b1; sleep_strobe = 1'b1;
    tick();
    sleep_strobe = 1'b0; standby_sel = 1'b0;
    chk("R7 deep again", osc_en, 1'b0);
    t_reset(1'b0);
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
  end

  initial begin
    t_reset(1'b1);
    t_exec_exceptions();
    t_bus();
    t_sleep(0);
    t_sleep(1);
    t_sleep(2);
    t_refuse();
    t_standby();
    t_reset_from_standby();
    chk("R2 manual reset kept", rst_poweron, 1'b0);
    t_bus();
    tick();
    summary();
  end

endmodule